// File: doc/BRIEF.md
# Seven-Channel Circular Memory Mover

The block moves data items on a single-master memory bus. It has seven channels. Each channel holds a source address, a destination address, an item count and a control word, all written by software through a small register port. An active channel is granted the bus and moves one item per grant. The block reads one item from the source at the source item size and then writes it to the destination at the destination item size. The item is truncated or zero-extended to fit.

A channel runs in one of three directions: peripheral-to-memory, memory-to-peripheral or memory-to-memory. The two peripheral directions are paced. Each item waits for the channel's hardware request line or for its latched software trigger bit. Memory-to-memory channels run freely once enabled. When the count runs out, a normal channel switches itself off and raises its completion flag. A circular channel instead reloads its count and both start addresses, stays on, and raises no flag.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset every register of every channel reads zero, and bus_req, hw_ack and tc_irq are all low.
- R2: Register index is cfg_addr = {channel, reg}, with reg 0 = source address, 1 = destination address, 2 = count (low 16 bits) and 3 = control. Writing reg 0, 1 or 2 sets both the start value and the current value, and reads return the current value. Control bits: [0] enable, [1] circular, [3:2] direction (0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory), [5:4] source size, [7:6] destination size (0 = 8, 1 = 16, 2 = 32 bit), [8] source increment, [9] destination increment, [10] software trigger, [11] completion flag (read only). Channel index 7 reads zero.
- R3: Each item is one read at the source address with bus_size = source size, followed by one write at the destination address with bus_size = destination size. A request holds its address and direction until bus_ack.
- R4: The written data equals the read data masked to the smaller of the two sizes, with zeros above.
- R5: After each item, an address advances by 1, 2 or 4 (its own side's size) when its increment bit is set, and otherwise stays the same.
- R6: A paced channel moves no item while both its hardware request and its software trigger are low. A memory-to-memory channel needs neither.
- R7: When several channels are ready, the lowest-numbered one is served first, and each grant moves exactly one item.
- R8: For a paced channel, hw_ack pulses for exactly one cycle, in the cycle right after the destination write is acknowledged.
- R9: In normal mode, after the last item the count reads 0, the enable bit is clear and tc_irq for that channel is high.
- R10: In circular mode, after the last item the count and both addresses reload to their start values, the enable bit stays set and tc_irq stays low.
- R11: Setting the software trigger on a paced channel runs its whole count without any hardware request.
- R12: Any write to a channel's control register clears that channel's completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register index {channel, reg} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| hw_req | input | 7 | Per-channel hardware request |
| hw_ack | output | 7 | Per-channel one-cycle acknowledge |
| tc_irq | output | 7 | Per-channel completion flag |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 32 | Bus byte address |
| bus_size | output | 2 | Item size of the access |
| bus_wdata | output | 32 | Write data, right aligned |
| bus_rdata | input | 32 | Read data, right aligned |
| bus_ack | input | 1 | Access accepted |

## Verification
The bench builds the block with its default parameters: seven channels, 32-bit addresses and a 16-bit count. With seven channels, the arbiter is tested with channel 1 and channel 4 requesting in the same cycle. The one unused channel index of the 3-bit select is read back to show it is empty. The bench draws random size pairs, increment flags and counts of up to four items. It mixes these with directed truncation and zero-extension cases, and the responder adds a random delay of zero to two cycles before each acknowledge.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DATA_W = 32;

    localparam logic [1:0] REG_SRC = 2'd0;
    localparam logic [1:0] REG_DST = 2'd1;
    localparam logic [1:0] REG_CNT = 2'd2;
    localparam logic [1:0] REG_CTL = 2'd3;

    localparam int CTL_EN   = 0;
    localparam int CTL_CIRC = 1;
    localparam int CTL_DIR  = 2;
    localparam int CTL_SSZ  = 4;
    localparam int CTL_DSZ  = 6;
    localparam int CTL_SINC = 8;
    localparam int CTL_DINC = 9;
    localparam int CTL_SWT  = 10;

    localparam logic [1:0] DIR_MEM2MEM = 2'd2;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2,
        MV_ACK   = 2'd3
    } mv_state_e;

    function automatic logic [DATA_W-1:0] size_mask(logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [2:0] size_step(logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N  = 7,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CNTW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_reg,
    output logic [DATA_W-1:0] rd_data,
    input  logic              beat_done,
    input  logic              hw_req,
    output logic              ready,
    output logic              mem2mem,
    output logic [AW-1:0]     cur_src,
    output logic [AW-1:0]     cur_dst,
    output logic [1:0]        src_sz,
    output logic [1:0]        dst_sz,
    output logic              tc
);
    typedef struct packed {
        logic            en;
        logic            circ;
        logic [1:0]      dir;
        logic [1:0]      ssz;
        logic [1:0]      dsz;
        logic            sinc;
        logic            dinc;
        logic            swt;
        logic            tc;
        logic [AW-1:0]   src0;
        logic [AW-1:0]   dst0;
        logic [CNTW-1:0] cnt0;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [CNTW-1:0] cnt;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [AW-1:0] src_next, dst_next;

    always_comb begin
        src_next = ch_q.src + (ch_q.sinc ? AW'(size_step(ch_q.ssz)) : '0);
        dst_next = ch_q.dst + (ch_q.dinc ? AW'(size_step(ch_q.dsz)) : '0);
        ch_d = ch_q;
        if (beat_done) begin
            if (ch_q.cnt == CNTW'(1)) begin
                if (ch_q.circ) begin
                    ch_d.cnt = ch_q.cnt0;
                    ch_d.src = ch_q.src0;
                    ch_d.dst = ch_q.dst0;
                end else begin
                    ch_d.cnt = '0;
                    ch_d.src = src_next;
                    ch_d.dst = dst_next;
                    ch_d.en  = 1'b0;
                    ch_d.swt = 1'b0;
                    ch_d.tc  = 1'b1;
                end
            end else begin
                ch_d.cnt = ch_q.cnt - CNTW'(1);
                ch_d.src = src_next;
                ch_d.dst = dst_next;
            end
        end
        if (wr_en) begin
            case (wr_reg)
                REG_SRC: begin
                    ch_d.src0 = wr_data[AW-1:0];
                    ch_d.src  = wr_data[AW-1:0];
                end
                REG_DST: begin
                    ch_d.dst0 = wr_data[AW-1:0];
                    ch_d.dst  = wr_data[AW-1:0];
                end
                REG_CNT: begin
                    ch_d.cnt0 = wr_data[CNTW-1:0];
                    ch_d.cnt  = wr_data[CNTW-1:0];
                end
                default: begin
                    ch_d.en   = wr_data[CTL_EN];
                    ch_d.circ = wr_data[CTL_CIRC];
                    ch_d.dir  = wr_data[CTL_DIR+:2];
                    ch_d.ssz  = wr_data[CTL_SSZ+:2];
                    ch_d.dsz  = wr_data[CTL_DSZ+:2];
                    ch_d.sinc = wr_data[CTL_SINC];
                    ch_d.dinc = wr_data[CTL_DINC];
                    ch_d.swt  = wr_data[CTL_SWT];
                    ch_d.tc   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    always_comb begin
        case (rd_reg)
            REG_SRC: rd_data = DATA_W'(ch_q.src);
            REG_DST: rd_data = DATA_W'(ch_q.dst);
            REG_CNT: rd_data = DATA_W'(ch_q.cnt);
            default: rd_data = DATA_W'({ch_q.tc, ch_q.swt, ch_q.dinc, ch_q.sinc,
                                        ch_q.dsz, ch_q.ssz, ch_q.dir, ch_q.circ, ch_q.en});
        endcase
    end

    assign mem2mem = (ch_q.dir == DIR_MEM2MEM);
    assign ready   = ch_q.en && (ch_q.cnt != '0) && (mem2mem || hw_req || ch_q.swt);
    assign cur_src = ch_q.src;
    assign cur_dst = ch_q.dst;
    assign src_sz  = ch_q.ssz;
    assign dst_sz  = ch_q.dsz;
    assign tc      = ch_q.tc;
endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int NCH = 7,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_valid,
    input  logic [CHW-1:0]    grant_idx,
    input  logic [AW-1:0]     grant_src,
    input  logic [AW-1:0]     grant_dst,
    input  logic [1:0]        grant_ssz,
    input  logic [1:0]        grant_dsz,
    input  logic              grant_paced,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              beat_done,
    output logic [CHW-1:0]    beat_ch,
    output logic [NCH-1:0]    ack_vec
);
    typedef struct packed {
        mv_state_e         state;
        logic [CHW-1:0]    ch;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [1:0]        ssz;
        logic [1:0]        dsz;
        logic              paced;
        logic [DATA_W-1:0] data;
    } mover_t;

    mover_t mv_d, mv_q;

    always_comb begin
        mv_d      = mv_q;
        beat_done = 1'b0;
        case (mv_q.state)
            MV_IDLE: begin
                if (grant_valid) begin
                    mv_d.state = MV_READ;
                    mv_d.ch    = grant_idx;
                    mv_d.src   = grant_src;
                    mv_d.dst   = grant_dst;
                    mv_d.ssz   = grant_ssz;
                    mv_d.dsz   = grant_dsz;
                    mv_d.paced = grant_paced;
                end
            end
            MV_READ: begin
                if (bus_ack) begin
                    mv_d.data  = bus_rdata & size_mask(mv_q.ssz) & size_mask(mv_q.dsz);
                    mv_d.state = MV_WRITE;
                end
            end
            MV_WRITE: begin
                if (bus_ack) begin
                    beat_done  = 1'b1;
                    mv_d.state = MV_ACK;
                end
            end
            default: mv_d.state = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '{state: MV_IDLE, default: '0};
        else        mv_q <= mv_d;
    end

    assign bus_req   = (mv_q.state == MV_READ) || (mv_q.state == MV_WRITE);
    assign bus_we    = (mv_q.state == MV_WRITE);
    assign bus_addr  = bus_we ? mv_q.dst : mv_q.src;
    assign bus_size  = bus_we ? mv_q.dsz : mv_q.ssz;
    assign bus_wdata = mv_q.data;
    assign beat_ch   = mv_q.ch;

    for (genvar i = 0; i < NCH; i++) begin : g_ack
        assign ack_vec[i] = (mv_q.state == MV_ACK) && mv_q.paced && (mv_q.ch == CHW'(i));
    end
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
    import dma_pkg::*;
#(
    parameter int NCH  = 7,
    parameter int AW   = 32,
    parameter int CNTW = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CAW = CHW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CAW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [NCH-1:0]    hw_req,
    output logic [NCH-1:0]    hw_ack,
    output logic [NCH-1:0]    tc_irq,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    logic [CHW-1:0]    sel_ch;
    logic [1:0]        sel_reg;
    logic [DATA_W-1:0] c_rd   [NCH];
    logic [AW-1:0]     c_src  [NCH];
    logic [AW-1:0]     c_dst  [NCH];
    logic [1:0]        c_ssz  [NCH];
    logic [1:0]        c_dsz  [NCH];
    logic [NCH-1:0]    c_ready, c_m2m;

    logic              g_valid;
    logic [CHW-1:0]    g_idx;
    logic [AW-1:0]     g_src, g_dst;
    logic [1:0]        g_ssz, g_dsz;
    logic              g_paced;
    logic              beat_done;
    logic [CHW-1:0]    beat_ch;

    assign sel_ch  = cfg_addr[CAW-1:2];
    assign sel_reg = cfg_addr[1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_chan #(.AW(AW), .CNTW(CNTW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (sel_ch == CHW'(i))),
            .wr_reg    (sel_reg),
            .wr_data   (cfg_wdata),
            .rd_reg    (sel_reg),
            .rd_data   (c_rd[i]),
            .beat_done (beat_done && (beat_ch == CHW'(i))),
            .hw_req    (hw_req[i]),
            .ready     (c_ready[i]),
            .mem2mem   (c_m2m[i]),
            .cur_src   (c_src[i]),
            .cur_dst   (c_dst[i]),
            .src_sz    (c_ssz[i]),
            .dst_sz    (c_dsz[i]),
            .tc        (tc_irq[i])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        g_src     = '0;
        g_dst     = '0;
        g_ssz     = '0;
        g_dsz     = '0;
        g_paced   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_ch == CHW'(i)) cfg_rdata = c_rd[i];
            if (g_idx == CHW'(i)) begin
                g_src   = c_src[i];
                g_dst   = c_dst[i];
                g_ssz   = c_ssz[i];
                g_dsz   = c_dsz[i];
                g_paced = !c_m2m[i];
            end
        end
    end

    dma_prio_arb #(.N(NCH)) i_arb (
        .req   (c_ready),
        .valid (g_valid),
        .idx   (g_idx)
    );

    dma_mover #(.NCH(NCH), .AW(AW)) i_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (g_valid),
        .grant_idx   (g_idx),
        .grant_src   (g_src),
        .grant_dst   (g_dst),
        .grant_ssz   (g_ssz),
        .grant_dsz   (g_dsz),
        .grant_paced (g_paced),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ack     (bus_ack),
        .beat_done   (beat_done),
        .beat_ch     (beat_ch),
        .ack_vec     (hw_ack)
    );
endmodule

// File: rtl/dma_ring_checker.sv
module dma_ring_checker #(
    parameter int NCH = 7,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_we,
    input logic           bus_ack,
    input logic [AW-1:0]  bus_addr,
    input logic [1:0]     bus_size,
    input logic [31:0]    bus_wdata,
    input logic [NCH-1:0] hw_ack,
    input logic [NCH-1:0] tc_irq
);
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> $past(bus_req && !bus_we && bus_ack));

    a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (bus_size == 2'd0) |-> (bus_wdata[31:8] == 24'd0));

    a_r4_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (bus_size == 2'd1) |-> (bus_wdata[31:16] == 16'd0));

    a_r8_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_ack) |-> $past(bus_req && bus_we && bus_ack));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hw_ack));

    a_r8_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_ack) |=> (hw_ack == '0));

    a_r9_tc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tc_irq & ~$past(tc_irq))) |-> $past(bus_we && bus_ack));
endmodule

bind dma_ring_engine dma_ring_checker #(.NCH(NCH), .AW(AW)) i_ring_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .hw_ack    (hw_ack),
    .tc_irq    (tc_irq)
);

// File: tb/test_dma_ring_engine.sv
module test_dma_ring_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [6:0]  hw_req = '0;
    logic [6:0]  hw_ack, tc_irq;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int total = 0, fails = 0, cyc = 0;
    int wr_count = 0, last_wr_cyc = -10, ack_total = 0, ack_timing_err = 0, order_err = 0;
    int ack_log [16];
    int req_pend [NCH];
    int lat_cnt = 0;
    bit rd_seen = 0;
    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];

    dma_ring_engine i_dma_ring_engine (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor, memory responder and peripheral model in one process
    always @(negedge clk) begin
        if (|hw_ack) begin
            for (int i = 0; i < NCH; i++)
                if (hw_ack[i] && ack_total < 16) ack_log[ack_total] = i;
            ack_total++;
            if (cyc != last_wr_cyc + 1) ack_timing_err++;
        end
        if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            if (lat_cnt == 0) begin
                bus_ack = 1'b1;
                if (bus_we) begin
                    mem[bus_addr[7:0]] = bus_wdata;
                    wr_count++;
                    last_wr_cyc = cyc;
                    if (!rd_seen) order_err++;
                    rd_seen = 0;
                end else begin
                    bus_rdata = mem[bus_addr[7:0]];
                    rd_seen = 1;
                end
                lat_cnt = $urandom_range(0, 2);
            end else lat_cnt--;
        end
        for (int i = 0; i < NCH; i++) begin
            if (hw_req[i] && hw_ack[i]) hw_req[i] = 1'b0;
            else if (!hw_req[i] && req_pend[i] > 0) begin
                hw_req[i] = 1'b1;
                req_pend[i]--;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input int ch, input int r, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(ch * 4 + r); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input int ch, input int r, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 5'(ch * 4 + r);
        #1 v = cfg_rdata;
    endtask

    task automatic wait_tc(input int ch, input string req);
        int n = 0;
        while (!tc_irq[ch] && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) check(req, 32'(tc_irq[ch]), 32'd1);
    endtask

    task automatic wait_acks(input int target);
        int n = 0;
        while (ack_total < target && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) check("R8 ack wait", 32'(ack_total), 32'(target));
    endtask

    task automatic add_req(input int ch, input int n);
        @(posedge clk);
        req_pend[ch] += n;
    endtask

    function automatic logic [31:0] fmask(input int sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic int fstep(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction
    function automatic logic [31:0] mk_cfg(input int en, circ, dir, ssz, dsz, sinc, dinc, swt);
        return 32'(en) | (32'(circ) << 1) | (32'(dir) << 2) | (32'(ssz) << 4) | (32'(dsz) << 6)
             | (32'(sinc) << 8) | (32'(dinc) << 9) | (32'(swt) << 10);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL R3 watchdog: cycles %0d expected below %0d", cyc, 100000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v, acc;
        int seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        for (int i = 0; i < NCH; i++) req_pend[i] = 0;
        for (int a = 0; a < 256; a++) mem[a] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        acc = '0;
        for (int ch = 0; ch < NCH; ch++)
            for (int r = 0; r < 4; r++) begin reg_rd(ch, r, v); acc |= v; end
        check("R1 registers zero", acc, 32'd0);
        check("R1 bus_req low", 32'(bus_req), 32'd0);
        check("R1 ack and tc low", 32'({hw_ack, tc_irq}), 32'd0);

        // R2 register readback on channel 3, enable left clear
        begin
            logic [31:0] s, d, c, g;
            s = $urandom(); d = $urandom(); c = $urandom(); g = $urandom() & 32'h7FE;
            reg_wr(3, 0, s); reg_wr(3, 1, d); reg_wr(3, 2, c); reg_wr(3, 3, g);
            reg_rd(3, 0, v); check("R2 src readback", v, s);
            reg_rd(3, 1, v); check("R2 dst readback", v, d);
            reg_rd(3, 2, v); check("R2 count readback", v, c & 32'hFFFF);
            reg_rd(3, 3, v); check("R2 control readback", v, g);
            reg_rd(7, 3, v); check("R2 unused index", v, 32'd0);
            reg_wr(3, 3, 32'd0);
        end

        // R3 R4 R5 R9: memory-to-memory on channel 0, random and directed sizes
        for (int it = 0; it < 8; it++) begin
            int n, ssz, dsz, sinc, dinc, sb, db, w0, bad;
            n = $urandom_range(1, 4); ssz = $urandom_range(0, 2); dsz = $urandom_range(0, 2);
            sinc = $urandom_range(0, 1); dinc = $urandom_range(0, 1);
            if (it == 0) begin ssz = 2; dsz = 0; sinc = 0; dinc = 1; n = 3; end
            if (it == 1) begin ssz = 0; dsz = 2; sinc = 1; dinc = 0; n = 4; end
            for (int a = 0; a < 64; a++) mem[a] = $urandom();
            for (int a = 0; a < 256; a++) exp_mem[a] = mem[a];
            sb = sinc ? fstep(ssz) : 0; db = dinc ? fstep(dsz) : 0;
            for (int k = 0; k < n; k++)
                exp_mem[8'h80 + k * db] = exp_mem[8'h10 + k * sb] & fmask(ssz) & fmask(dsz);
            w0 = wr_count;
            reg_wr(0, 0, 32'h10); reg_wr(0, 1, 32'h80); reg_wr(0, 2, 32'(n));
            reg_wr(0, 3, mk_cfg(1, 0, 2, ssz, dsz, sinc, dinc, 0));
            wait_tc(0, "R9 completion");
            bad = 0;
            for (int a = 128; a < 192; a++) if (mem[a] !== exp_mem[a]) bad++;
            check("R4 destination contents", 32'(bad), 32'd0);
            check("R3 write beats", 32'(wr_count - w0), 32'(n));
            reg_rd(0, 0, v); check("R5 final source address", v, 32'(16 + n * sb));
            reg_rd(0, 1, v); check("R5 final destination address", v, 32'(128 + n * db));
            reg_rd(0, 2, v); check("R9 count zero", v, 32'd0);
            reg_rd(0, 3, v); check("R9 enable clear and flag set", {v[11], v[0]}, 32'b10);
        end
        check("R3 read precedes write", 32'(order_err), 32'd0);

        // R6 R8: paced peripheral-to-memory on channel 2
        begin
            int w0, a0;
            w0 = wr_count; a0 = ack_total;
            reg_wr(2, 0, 32'h40); reg_wr(2, 1, 32'hC0); reg_wr(2, 2, 32'd3);
            reg_wr(2, 3, mk_cfg(1, 0, 0, 2, 2, 0, 1, 0));
            repeat (20) @(negedge clk);
            reg_rd(2, 2, v); check("R6 no request no movement", v, 32'd3);
            check("R6 no bus writes", 32'(wr_count - w0), 32'd0);
            add_req(2, 1);
            wait_acks(a0 + 1);
            repeat (2) @(negedge clk);
            reg_rd(2, 2, v); check("R6 one item per request", v, 32'd2);
            add_req(2, 2);
            wait_tc(2, "R9 paced completion");
            repeat (3) @(negedge clk);
            check("R8 one pulse per item", 32'(ack_total - a0), 32'd3);
            check("R8 pulse follows write ack", 32'(ack_timing_err), 32'd0);
        end

        // R11: software trigger on paced channel 3
        begin
            int w0;
            w0 = wr_count;
            reg_wr(3, 0, 32'h20); reg_wr(3, 1, 32'hD0); reg_wr(3, 2, 32'd2);
            reg_wr(3, 3, mk_cfg(1, 0, 1, 1, 1, 1, 1, 1));
            wait_tc(3, "R11 software trigger");
            check("R11 items moved without request", 32'(wr_count - w0), 32'd2);
            reg_rd(3, 3, v); check("R11 trigger and enable dropped", {v[10], v[0]}, 32'd0);
        end

        // R7: channels 1 and 4 requesting together
        begin
            int a0;
            reg_wr(1, 0, 32'h30); reg_wr(1, 1, 32'hE0); reg_wr(1, 2, 32'd1);
            reg_wr(4, 0, 32'h34); reg_wr(4, 1, 32'hE8); reg_wr(4, 2, 32'd1);
            reg_wr(1, 3, mk_cfg(1, 0, 1, 2, 2, 1, 1, 0));
            reg_wr(4, 3, mk_cfg(1, 0, 1, 2, 2, 1, 1, 0));
            a0 = ack_total;
            @(posedge clk);
            req_pend[1] += 1; req_pend[4] += 1;
            wait_acks(a0 + 2);
            check("R7 lowest index served first", 32'(ack_log[a0]), 32'd1);
            check("R7 other channel served next", 32'(ack_log[a0 + 1]), 32'd4);
            check("R7 both complete", 32'({tc_irq[4], tc_irq[1]}), 32'b11);
        end

        // R10: circular paced channel 6, five items with count three
        begin
            int a0;
            a0 = ack_total;
            reg_wr(6, 0, 32'h08); reg_wr(6, 1, 32'hF0); reg_wr(6, 2, 32'd3);
            reg_wr(6, 3, mk_cfg(1, 1, 0, 0, 1, 1, 1, 0));
            add_req(6, 5);
            wait_acks(a0 + 5);
            repeat (2) @(negedge clk);
            reg_rd(6, 2, v); check("R10 count after reload", v, 32'd1);
            reg_rd(6, 0, v); check("R10 source reloaded", v, 32'h0A);
            reg_rd(6, 1, v); check("R10 destination reloaded", v, 32'hF4);
            reg_rd(6, 3, v); check("R10 stays enabled without flag", {v[11], v[0]}, 32'b01);
            check("R10 no completion output", 32'(tc_irq[6]), 32'd0);
            reg_wr(6, 3, 32'd0);
        end

        // R12: control write clears the completion flag
        check("R12 flag set before", 32'(tc_irq[0]), 32'd1);
        reg_wr(0, 3, mk_cfg(0, 0, 2, 2, 2, 0, 0, 0));
        @(negedge clk);
        check("R12 flag cleared by control write", 32'(tc_irq[0]), 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule